// File: doc/BRIEF.md
# PMIC Bus Command Channel

This block is the host-facing side of a single command channel that reaches power-management slaves over a serial bus. Software loads up to two payload words, then writes a command word naming an opcode, a 4-bit slave ID, a 16-bit register address and a byte count. The channel decodes the command and hands the fields to a bus-side transaction engine with a one-cycle start pulse. It then waits for the engine to report completion, latching a done flag with three independent error flags. Read payload returned by the engine is captured into two read words.

A busy flag holds off further commands until the engine reports back or a cycle-count timeout fires. Payload bytes travel little-endian across the two 32-bit words. Bytes beyond the requested count are forced to zero in both directions. Opcodes outside the defined set are refused locally and never reach the engine.

Top module: `pmcc_channel`

## Requirements
- R1: While a command is held, eng_opcode, eng_slave, eng_addr and eng_bc equal command-word bits 31:27, 23:20, 19:4 and 2:0 respectively.
- R2: A command-register write (offset 0) while idle with a defined opcode raises eng_start for exactly the one cycle after the write edge, sets chan_busy and clears the status word to 0.
- R3: eng_kind reports 1 (write) for opcodes 0, 2, 9, 14, 16; 2 (read) for opcodes 1, 8, 13, 15; 0 (non-data) for opcodes 3 to 7.
- R4: A command write with any other opcode (10 to 12, 17 to 31) gives no start pulse and leaves chan_busy low. eng_kind reads 3, and the status word reads 0x03 (done plus failure) after that edge.
- R5: eng_wpayload byte i (bits 8i+7:8i) equals byte i mod 4 of write word i/4 (offset 1 for bytes 0 to 3, offset 2 for bytes 4 to 7, lowest byte in bits 7:0) when i is at most eng_bc, and zero otherwise.
- R6: eng_done while busy clears chan_busy. It loads the status word with done at bit 0 and eng_fail, eng_deny and eng_drop at bits 1, 2 and 3.
- R7: On an error-free completion, the read words (offset 3 for bytes 0 to 3, offset 4 for bytes 4 to 7, little-endian) hold eng_rpayload bytes 0 to eng_bc with higher bytes zero. On a completion with any error bit, both read words are zero.
- R8: A command write while busy is ignored: no start pulse, the command readback is unchanged and the status word is unchanged.
- R9: If no eng_done arrives within TMO_CYC cycles of the accepting edge, chan_busy clears on that edge and the status word becomes 0x10 (timeout at bit 4). The value holds until the next accepted command clears it.
- R10: eng_done while idle has no effect on the status word or the read words.
- R11: After reset, every readable register is zero, chan_busy is low and eng_start is low.
- R12: Register reads return command (0), write word 0 (1), write word 1 (2), read word 0 (3), read word 1 (4), status (5), and zero for other offsets. Writes to offsets 3 to 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | RA_W | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | RA_W | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| chan_busy | output | 1 | A command is outstanding |
| eng_start | output | 1 | One-cycle launch toward the transaction engine |
| eng_kind | output | 2 | Opcode class: 0 non-data, 1 write, 2 read, 3 undefined |
| eng_opcode | output | 5 | Opcode field of the held command |
| eng_slave | output | 4 | Slave ID field |
| eng_addr | output | 16 | Register address field |
| eng_bc | output | 3 | Byte count minus one |
| eng_wpayload | output | 64 | Write payload, byte-masked |
| eng_done | input | 1 | Engine completion strobe |
| eng_fail | input | 1 | Completion carried a failure |
| eng_deny | input | 1 | Completion carried a denial |
| eng_drop | input | 1 | Completion was dropped |
| eng_rpayload | input | 64 | Read payload returned by the engine |

## Verification
All 32 opcode values are swept with a varying byte count. A decoder that misclassifies an edge value such as 9, 16 or 10 would start an undefined command or refuse a legal one. Every byte count meets both payload directions, so an off-by-one mask would leak a stale byte or cut the last one. All eight error-flag combinations are driven on read completions, which exposes swapped status bits and read data kept after an error. The bench also sends a command while busy, a completion while idle and a timeout at the exact boundary cycle. A one-off counter shows up as chan_busy clearing a cycle early or late.

// File: rtl/pmcc_pkg.sv
`timescale 1ns/1ps
package pmcc_pkg;
  localparam int CMD_W    = 32;
  localparam int OP_W     = 5;
  localparam int SID_W    = 4;
  localparam int RADR_W   = 16;
  localparam int BC_W     = 3;
  localparam int OP_LSB   = 27;
  localparam int SID_LSB  = 20;
  localparam int RADR_LSB = 4;
  localparam int STAT_W   = 5;

  // register offsets
  localparam int OFS_CMD  = 0;
  localparam int OFS_WD0  = 1;
  localparam int OFS_WD1  = 2;
  localparam int OFS_RD0  = 3;
  localparam int OFS_RD1  = 4;
  localparam int OFS_STAT = 5;

  typedef enum logic [1:0] {
    KIND_NODATA = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_READ   = 2'd2,
    KIND_BAD    = 2'd3
  } op_kind_e;

  function automatic op_kind_e classify(input logic [OP_W-1:0] op);
    case (op)
      5'd0, 5'd2, 5'd9, 5'd14, 5'd16: return KIND_WRITE;
      5'd1, 5'd8, 5'd13, 5'd15:       return KIND_READ;
      5'd3, 5'd4, 5'd5, 5'd6, 5'd7:   return KIND_NODATA;
      default:                        return KIND_BAD;
    endcase
  endfunction

  // status word produced by a completion report
  function automatic logic [STAT_W-1:0] end_status(input logic fail, input logic deny,
                                                   input logic drop);
    return {1'b0, drop, deny, fail, 1'b1};
  endfunction

  localparam logic [STAT_W-1:0] STAT_REFUSED = 5'b00011;
  localparam logic [STAT_W-1:0] STAT_TMO     = 5'b10000;
endpackage

// File: rtl/pmcc_cmd_decode.sv
`timescale 1ns/1ps
module pmcc_cmd_decode
  import pmcc_pkg::*;
(
  input  logic [CMD_W-1:0]  cmd,
  output logic [OP_W-1:0]   opcode,
  output logic [SID_W-1:0]  slave,
  output logic [RADR_W-1:0] radr,
  output logic [BC_W-1:0]   bc,
  output logic [1:0]        kind
);
  logic unused_pad;
  assign unused_pad = cmd[3];

  assign opcode = cmd[OP_LSB +: OP_W];
  assign slave  = cmd[SID_LSB +: SID_W];
  assign radr   = cmd[RADR_LSB +: RADR_W];
  assign bc     = cmd[BC_W-1:0];
  assign kind   = classify(opcode);
endmodule

// File: rtl/pmcc_byte_keep.sv
`timescale 1ns/1ps
module pmcc_byte_keep #(
  parameter int N_BYTES = 8,
  parameter int BC_W    = 3
) (
  input  logic [8*N_BYTES-1:0] din,
  input  logic [BC_W-1:0]      last,
  output logic [8*N_BYTES-1:0] dout
);
  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign dout[8*b +: 8] = (last >= BC_W'(b)) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/pmcc_flow.sv
`timescale 1ns/1ps
module pmcc_flow
  import pmcc_pkg::*;
#(
  parameter int TMO_CYC = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_bad,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              eng_deny,
  input  logic              eng_drop,
  output logic              busy,
  output logic              start,
  output logic              finish,
  output logic              finish_ok,
  output logic [STAT_W-1:0] status
);
  localparam int CNT_W = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] wait_cnt;
  logic             expire;

  assign finish    = busy && eng_done;
  assign finish_ok = finish && !(eng_fail || eng_deny || eng_drop);
  assign expire    = busy && !eng_done && (wait_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      start    <= 1'b0;
      status   <= '0;
      wait_cnt <= '0;
    end else begin
      start <= launch && !launch_bad;
      if (launch) begin
        wait_cnt <= '0;
        busy     <= !launch_bad;
        status   <= launch_bad ? STAT_REFUSED : '0;
      end else if (finish) begin
        busy   <= 1'b0;
        status <= end_status(eng_fail, eng_deny, eng_drop);
      end else if (expire) begin
        busy   <= 1'b0;
        status <= STAT_TMO;
      end else if (busy) begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmcc_channel.sv
`timescale 1ns/1ps
module pmcc_channel
  import pmcc_pkg::*;
#(
  parameter int TMO_CYC = 20000,
  parameter int RA_W    = 3,
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_we,
  input  logic [RA_W-1:0]           reg_waddr,
  input  logic [31:0]               reg_wdata,
  input  logic [RA_W-1:0]           reg_raddr,
  output logic [31:0]               reg_rdata,
  output logic                      chan_busy,
  output logic                      eng_start,
  output logic [1:0]                eng_kind,
  output logic [4:0]                eng_opcode,
  output logic [3:0]                eng_slave,
  output logic [15:0]               eng_addr,
  output logic [2:0]                eng_bc,
  output logic [WORD_W*N_WORDS-1:0] eng_wpayload,
  input  logic                      eng_done,
  input  logic                      eng_fail,
  input  logic                      eng_deny,
  input  logic                      eng_drop,
  input  logic [WORD_W*N_WORDS-1:0] eng_rpayload
);
  localparam int PAY_W   = WORD_W * N_WORDS;
  localparam int N_BYTES = PAY_W / 8;

  logic [CMD_W-1:0]  cmd_q;
  logic [WORD_W-1:0] wd_q [N_WORDS];
  logic [PAY_W-1:0]  rd_q;
  logic [PAY_W-1:0]  wd_flat;
  logic [PAY_W-1:0]  rd_keep;
  logic [STAT_W-1:0] stat;

  // named internal events
  logic cmd_wr, launch, launch_bad, finish, finish_ok;

  assign cmd_wr     = reg_we && (reg_waddr == RA_W'(OFS_CMD));
  assign launch     = cmd_wr && !chan_busy;
  assign launch_bad = classify(reg_wdata[OP_LSB +: OP_W]) == KIND_BAD;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_wd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          wd_q[w] <= '0;
      else if (reg_we && reg_waddr == RA_W'(OFS_WD0 + w))  wd_q[w] <= reg_wdata;
    end
    assign wd_flat[WORD_W*w +: WORD_W] = wd_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (launch) cmd_q <= reg_wdata;
  end

  pmcc_cmd_decode u_dec (
    .cmd(cmd_q), .opcode(eng_opcode), .slave(eng_slave),
    .radr(eng_addr), .bc(eng_bc), .kind(eng_kind)
  );

  pmcc_byte_keep #(.N_BYTES(N_BYTES), .BC_W(BC_W)) u_wkeep (
    .din(wd_flat), .last(eng_bc), .dout(eng_wpayload)
  );

  pmcc_byte_keep #(.N_BYTES(N_BYTES), .BC_W(BC_W)) u_rkeep (
    .din(eng_rpayload), .last(eng_bc), .dout(rd_keep)
  );

  pmcc_flow #(.TMO_CYC(TMO_CYC)) u_flow (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_bad(launch_bad),
    .eng_done(eng_done), .eng_fail(eng_fail), .eng_deny(eng_deny), .eng_drop(eng_drop),
    .busy(chan_busy), .start(eng_start), .finish(finish), .finish_ok(finish_ok),
    .status(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (launch) rd_q <= '0;
    else if (finish) rd_q <= finish_ok ? rd_keep : '0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == RA_W'(OFS_CMD))       reg_rdata = cmd_q;
    else if (reg_raddr == RA_W'(OFS_STAT)) reg_rdata = 32'(stat);
    else begin
      for (int w = 0; w < N_WORDS; w++) begin
        if (reg_raddr == RA_W'(OFS_WD0 + w)) reg_rdata = wd_q[w];
        if (reg_raddr == RA_W'(OFS_RD0 + w)) reg_rdata = rd_q[WORD_W*w +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/pmcc_chk.sv
`timescale 1ns/1ps
module pmcc_chk #(
  parameter int N_BYTES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_wr,
  input logic                 launch,
  input logic                 launch_bad,
  input logic                 chan_busy,
  input logic                 eng_start,
  input logic                 eng_done,
  input logic [4:0]           stat,
  input logic [31:0]          cmd_q,
  input logic [8*N_BYTES-1:0] rd_q
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> chan_busy);
  assert_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch && launch_bad |=> !eng_start && !chan_busy && stat == 5'b00011);
  assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chan_busy && eng_done |=> !chan_busy && stat[0]);
  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_busy && cmd_wr |=> $stable(cmd_q) && !eng_start);
  assert_ended_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] || stat[4]) |-> !chan_busy);
  assert_tmo_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[0] && stat[4]));
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_busy && !launch && eng_done |=> $stable(stat) && $stable(rd_q));

  for (genvar b = 0; b < N_BYTES; b++) begin : g_rz
    assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[2:0] < 3'(b)) |-> rd_q[8*b +: 8] == 8'h00);
  end
endmodule

bind pmcc_channel pmcc_chk #(.N_BYTES(N_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .launch(launch), .launch_bad(launch_bad),
  .chan_busy(chan_busy), .eng_start(eng_start), .eng_done(eng_done), .stat(stat),
  .cmd_q(cmd_q), .rd_q(rd_q)
);

// File: tb/pmcc_channel_bench.sv
`timescale 1ns/1ps
module pmcc_channel_bench;
  localparam int TMO = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        chan_busy, eng_start;
  logic [1:0]  eng_kind;
  logic [4:0]  eng_opcode;
  logic [3:0]  eng_slave;
  logic [15:0] eng_addr;
  logic [2:0]  eng_bc;
  logic [63:0] eng_wpayload;
  logic        eng_done = 1'b0, eng_fail = 1'b0, eng_deny = 1'b0, eng_drop = 1'b0;
  logic [63:0] eng_rpayload = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  pmcc_channel #(.TMO_CYC(TMO)) u_pmcc_channel (.*);

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [31:0] d);
    reg_raddr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic engine_report(input logic f, input logic dn, input logic dr,
                               input logic [63:0] rp);
    @(negedge clk);
    eng_done = 1'b1; eng_fail = f; eng_deny = dn; eng_drop = dr; eng_rpayload = rp;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0; eng_deny = 1'b0; eng_drop = 1'b0;
  endtask

  function automatic logic [1:0] exp_kind(input int op);
    if (op == 0 || op == 2 || op == 9 || op == 14 || op == 16) return 2'd1;
    if (op == 1 || op == 8 || op == 13 || op == 15)           return 2'd2;
    if (op >= 3 && op <= 7)                                   return 2'd0;
    return 2'd3;
  endfunction

  function automatic logic [63:0] keep_bytes(input logic [63:0] d, input int bc);
    logic [63:0] r = '0;
    for (int i = 0; i <= bc; i++) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, cmd;
    logic [63:0] wd, rp, expr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      host_rd(3'(a), v);
      check(v == 0, "R11 reset reg", v, 0);
    end
    check(!chan_busy && !eng_start, "R11 busy/start", {chan_busy, eng_start}, 0);

    // R12 register map and read-only words
    host_wr(3'(1), 32'h1122_3344);
    host_wr(3'(2), 32'h5566_7788);
    host_wr(3'(3), 32'hFFFF_FFFF);
    host_wr(3'(5), 32'hFFFF_FFFF);
    host_rd(3'(1), v); check(v == 32'h1122_3344, "R12 wd0 readback", v, 32'h1122_3344);
    host_rd(3'(2), v); check(v == 32'h5566_7788, "R12 wd1 readback", v, 32'h5566_7788);
    host_rd(3'(3), v); check(v == 0, "R12 rd0 not writable", v, 0);
    host_rd(3'(5), v); check(v == 0, "R12 status not writable", v, 0);

    // opcode sweep: R1 R2 R3 R4 R5 R6 R7
    for (int op = 0; op < 32; op++) begin
      int bc = op % 8;
      logic [3:0] sid = 4'(op * 7);
      logic [15:0] adr = 16'(16'hA53C ^ (op * 16'h0101));
      wd = {32'(32'h9000_0000 + op * 32'h0103_0507), 32'(32'h1F2E_3D4C ^ op)};
      host_wr(3'(1), wd[31:0]);
      host_wr(3'(2), wd[63:32]);
      cmd = {5'(op), 3'b000, sid, adr, 1'b0, 3'(bc)};
      host_wr(3'(0), cmd);
      check(eng_kind == exp_kind(op), "R3 kind", eng_kind, exp_kind(op));
      if (exp_kind(op) == 2'd3) begin
        check(!eng_start && !chan_busy, "R4 refused no start", {eng_start, chan_busy}, 0);
        host_rd(3'(5), v); check(v == 32'h3, "R4 refused status", v, 32'h3);
      end else begin
        check(eng_start && chan_busy, "R2 start pulse", {eng_start, chan_busy}, 2'b11);
        host_rd(3'(5), v); check(v == 0, "R2 status cleared", v, 0);
        check(eng_opcode == 5'(op) && eng_slave == sid && eng_addr == adr && eng_bc == 3'(bc),
              "R1 fields", {eng_opcode, eng_slave, eng_addr, eng_bc},
              {5'(op), sid, adr, 3'(bc)});
        check(eng_wpayload == keep_bytes(wd, bc), "R5 write payload", eng_wpayload,
              keep_bytes(wd, bc));
        host_rd(3'(0), v); check(v == cmd, "R12 cmd readback", v, cmd);
        @(negedge clk);
        check(!eng_start, "R2 start single cycle", eng_start, 0);
        rp = {32'hCAFE_0000 | 32'(op), 32'hBEEF_0000 | 32'(op * 3)};
        engine_report(1'b0, 1'b0, 1'b0, rp);
        check(!chan_busy, "R6 busy cleared", chan_busy, 0);
        host_rd(3'(5), v); check(v == 32'h1, "R6 clean status", v, 1);
        expr = keep_bytes(rp, bc);
        host_rd(3'(3), v); host_rd(3'(4), v2);
        check({v2, v} == expr, "R7 read words", {v2, v}, expr);
      end
    end

    // error flag sweep: R6 R7
    for (int e = 0; e < 8; e++) begin
      host_wr(3'(0), {5'd15, 3'b0, 4'h3, 16'h0042, 1'b0, 3'd7});
      rp = 64'h0123_4567_89AB_CDEF;
      engine_report(e[0], e[1], e[2], rp);
      host_rd(3'(5), v);
      check(v == {27'b0, 1'b0, e[2], e[1], e[0], 1'b1}, "R6 error bits", v,
            {27'b0, 1'b0, e[2], e[1], e[0], 1'b1});
      expr = (e == 0) ? rp : 64'h0;
      host_rd(3'(3), v); host_rd(3'(4), v2);
      check({v2, v} == expr, "R7 error read zero", {v2, v}, expr);
    end

    // R8 command while busy
    cmd = {5'd14, 3'b0, 4'h1, 16'h1234, 1'b0, 3'd0};
    host_wr(3'(0), cmd);
    @(negedge clk);
    host_wr(3'(0), {5'd15, 3'b0, 4'h2, 16'h9999, 1'b0, 3'd2});
    check(!eng_start && chan_busy, "R8 no start while busy", {eng_start, chan_busy}, 1);
    host_rd(3'(0), v); check(v == cmd, "R8 cmd unchanged", v, cmd);
    host_rd(3'(5), v); check(v == 0, "R8 status unchanged", v, 0);
    engine_report(1'b0, 1'b0, 1'b0, 64'h0);

    // R9 timeout boundary
    host_wr(3'(0), {5'd4, 3'b0, 4'h5, 16'h0, 1'b0, 3'd0});
    repeat (TMO - 1) @(negedge clk);
    check(chan_busy, "R9 busy before expiry", chan_busy, 1);
    host_rd(3'(5), v); check(v == 0, "R9 status before expiry", v, 0);
    @(negedge clk);
    check(!chan_busy, "R9 busy cleared at expiry", chan_busy, 0);
    host_rd(3'(5), v); check(v == 32'h10, "R9 timeout status", v, 32'h10);
    repeat (5) @(negedge clk);
    host_rd(3'(5), v); check(v == 32'h10, "R9 timeout sticky", v, 32'h10);

    // R10 done while idle
    engine_report(1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    host_rd(3'(5), v); check(v == 32'h10, "R10 idle done status", v, 32'h10);
    host_rd(3'(3), v); check(v == 0, "R10 idle done read word", v, 0);

    host_wr(3'(0), {5'd6, 3'b0, 4'h0, 16'h0, 1'b0, 3'd0});
    host_rd(3'(5), v); check(v == 0, "R9 new command clears timeout", v, 0);
    engine_report(1'b0, 1'b0, 1'b0, 64'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule